// File: doc/BRIEF.md
# Object Handle Hash Lookup

This block turns a 32-bit object handle into an object descriptor. It hashes the handle with an XOR fold, mixes in the requesting channel, and reads one 8-byte entry from a hash table in instance memory. The lookup is started by a one-cycle pulse. A size code sets the table size and, with it, the fold width. A base field places the table in memory on a 4 KiB boundary.

The entry is fetched as two 32-bit words over a request/ready read port. The request is held until ready is seen, and the read data must be valid in that same cycle. Each word carries byte address A in bits 7:0 and address A+3 in bits 31:24 (little-endian). The first word is the stored handle. The second is a context word, which is split into an instance address, an engine number, a channel number and a valid flag.

The block does not probe for collisions and does not compare the stored handle with the requested one. Those decisions stay with the consumer of the descriptor. A hash whose entry would lie outside the table is reported on an error pulse, and no memory read is issued for it.

Top module: `objhash_lookup`

## Requirements
- R1: The table holds 2^(size_i+12) bytes, and the fold chunk width is size_i+11 bits.
- R2: The hash starts at zero and XORs in the low chunk of the remaining handle, then shifts that handle right by the chunk width, one chunk per clock, until the remainder is zero. The result is then XORed with chan_i shifted left by (chunk width − 4).
- R3: If hash×8 is at least the table size, err_o is high for exactly one cycle. No memory request is made, done_o stays low and the descriptor outputs keep their previous values.
- R4: The handle word is read at (base_i×4096 + hash×8) and the context word at that address + 4. mem_req_o and mem_addr_o stay stable until mem_ready_i is seen high at a clock edge.
- R5: From the context word: ent_inst_o = bits 15:0 shifted left by 4, ent_engine_o = bits 17:16, ent_chan_o = bits 28:24 and ent_valid_o = bit 31. All other context bits are ignored.
- R6: ent_handle_o equals the first word read.
- R7: done_o is high for one cycle, starting with the cycle after the edge that accepts the context word. The descriptor outputs change only at that edge and hold until the next one.
- R8: start_i is ignored while a lookup is in progress, and the inputs of an ignored start have no effect on the result.
- R9: While reset is applied, mem_req_o, done_o and err_o are low and all descriptor outputs are zero.
- R10: For a handle that splits into k nonzero-remainder chunks, either err_o or the first memory request appears k+1 clock edges after the edge that accepts start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| handle_i | input | 32 | Object handle to look up |
| chan_i | input | 5 | Requesting channel number |
| size_i | input | 2 | Table size code |
| base_i | input | 20 | Table base in 4 KiB units |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Byte address of the word requested |
| mem_ready_i | input | 1 | Read accepted; data valid this cycle |
| mem_rdata_i | input | 32 | Read data, little-endian |
| done_o | output | 1 | Descriptor valid pulse |
| err_o | output | 1 | Entry out of table range pulse |
| ent_handle_o | output | 32 | Stored handle word |
| ent_inst_o | output | 20 | Instance byte address |
| ent_engine_o | output | 2 | Engine number |
| ent_chan_o | output | 5 | Channel number from the entry |
| ent_valid_o | output | 1 | Entry valid flag |

## Verification
After the edge that takes start_i, the range decision (an error pulse or the first request) is due k+1 edges later, where k is the number of folded chunks. Each request word is consumed at the first edge where ready is high. The descriptor and done_o change at the edge that consumes the context word. A behavioural model in the bench advances on the same rising edges from the same inputs. The bench compares every output with that model at each falling edge, so a result that arrives a cycle early or late fails where it lands. Ready is driven both always-high and in a random stall pattern, so the hold-until-ready behaviour and the done timing are exercised under both.

// File: rtl/objhash_pkg.sv
package objhash_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FOLD   = 2'd1,
      ST_RD_HDL = 2'd2,
      ST_RD_CTX = 2'd3
   } lk_state_e;

   // widest hash a size code range and channel width can produce
   function automatic int hash_width(input int log2_min, input int size_w, input int chan_w);
      int bw_max;
      bw_max = log2_min + (1 << size_w) - 2;
      return (chan_w > 4) ? (bw_max - 4 + chan_w) : bw_max;
   endfunction

endpackage

// File: rtl/objhash_fold.sv
module objhash_fold #(
   parameter int HANDLE_W   = 32,
   parameter int CHAN_W     = 5,
   parameter int SIZE_W     = 2,
   parameter int LOG2_MIN   = 12,
   parameter int ENTRY_LOG2 = 3,
   parameter int HASH_W     = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic                step_i,
   input  logic [HANDLE_W-1:0] handle_i,
   input  logic [CHAN_W-1:0]   chan_i,
   input  logic [SIZE_W-1:0]   size_i,
   output logic                rem_zero_o,
   output logic [HASH_W-1:0]   hash_o,
   output logic                in_range_o
);

   localparam int NSZ    = 1 << SIZE_W;
   localparam int BW_MAX = LOG2_MIN + NSZ - 2;

   if (LOG2_MIN < 5) begin : g_bad_min
      $error("objhash_fold: LOG2_MIN must be at least 5");
   end
   if (BW_MAX >= HANDLE_W) begin : g_bad_handle
      $error("objhash_fold: widest chunk must be narrower than the handle");
   end
   if (LOG2_MIN <= ENTRY_LOG2) begin : g_bad_entry
      $error("objhash_fold: table must hold more than one entry");
   end
   if (HASH_W < BW_MAX) begin : g_bad_hash
      $error("objhash_fold: HASH_W too small");
   end

   logic [HANDLE_W-1:0] rem_q;
   logic [HASH_W-1:0]   acc_q;
   logic [CHAN_W-1:0]   chan_q;
   logic [SIZE_W-1:0]   size_q;

   logic [HASH_W-1:0]   chunk_v [NSZ];
   logic [HANDLE_W-1:0] rem_nxt_v [NSZ];
   logic [HASH_W-1:0]   final_v [NSZ];
   logic                fit_v [NSZ];

   // one lane per size code: chunk width, channel position and range limit
   for (genvar g = 0; g < NSZ; g++) begin : g_lane
      localparam int BW = LOG2_MIN + g - 1;
      logic [HASH_W-1:0] chan_term;
      assign chunk_v[g]   = HASH_W'(rem_q[BW-1:0]);
      assign rem_nxt_v[g] = rem_q >> BW;
      assign chan_term    = HASH_W'(chan_q) << (BW - 4);
      assign final_v[g]   = acc_q ^ chan_term;
      assign fit_v[g]     = (final_v[g] >> (LOG2_MIN + g - ENTRY_LOG2)) == '0;
   end

   assign rem_zero_o = (rem_q == '0);
   assign hash_o     = final_v[size_q];
   assign in_range_o = fit_v[size_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         acc_q  <= '0;
         chan_q <= '0;
         size_q <= '0;
      end else if (load_i) begin
         rem_q  <= handle_i;
         acc_q  <= '0;
         chan_q <= chan_i;
         size_q <= size_i;
      end else if (step_i && !rem_zero_o) begin
         rem_q  <= rem_nxt_v[size_q];
         acc_q  <= acc_q ^ chunk_v[size_q];
      end
   end

endmodule

// File: rtl/objhash_ctx_decode.sv
module objhash_ctx_decode #(
   parameter int DATA_W     = 32,
   parameter int INST_W     = 16,
   parameter int INST_SHIFT = 4,
   parameter int ENG_LSB    = 16,
   parameter int ENG_W      = 2,
   parameter int CHAN_LSB   = 24,
   parameter int CHAN_W     = 5,
   parameter int VALID_BIT  = 31
) (
   input  logic [DATA_W-1:0]            ctx_i,
   output logic [INST_W+INST_SHIFT-1:0] inst_o,
   output logic [ENG_W-1:0]             eng_o,
   output logic [CHAN_W-1:0]            chan_o,
   output logic                         valid_o
);

   if (INST_W > DATA_W || ENG_LSB + ENG_W > DATA_W ||
       CHAN_LSB + CHAN_W > DATA_W || VALID_BIT >= DATA_W) begin : g_bad_field
      $error("objhash_ctx_decode: a context field lies outside the word");
   end

   if (INST_SHIFT == 0) begin : g_inst_plain
      assign inst_o = ctx_i[INST_W-1:0];
   end else begin : g_inst_scaled
      assign inst_o = {ctx_i[INST_W-1:0], {INST_SHIFT{1'b0}}};
   end

   assign eng_o   = ctx_i[ENG_LSB +: ENG_W];
   assign chan_o  = ctx_i[CHAN_LSB +: CHAN_W];
   assign valid_o = ctx_i[VALID_BIT];

   logic unused_ctx_bits;
   assign unused_ctx_bits = ^ctx_i;

endmodule

// File: rtl/objhash_lookup.sv
module objhash_lookup
   import objhash_pkg::*;
#(
   parameter int HANDLE_W   = 32,
   parameter int CHAN_W     = 5,
   parameter int SIZE_W     = 2,
   parameter int LOG2_MIN   = 12,
   parameter int ENTRY_LOG2 = 3,
   parameter int BASE_W     = 20,
   parameter int PAGE_LOG2  = 12,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int INST_W     = 16,
   parameter int INST_SHIFT = 4,
   parameter int ENG_LSB    = 16,
   parameter int ENG_W      = 2,
   parameter int CHAN_LSB   = 24,
   parameter int VALID_BIT  = 31
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [HANDLE_W-1:0]          handle_i,
   input  logic [CHAN_W-1:0]            chan_i,
   input  logic [SIZE_W-1:0]            size_i,
   input  logic [BASE_W-1:0]            base_i,
   output logic                         mem_req_o,
   output logic [ADDR_W-1:0]            mem_addr_o,
   input  logic                         mem_ready_i,
   input  logic [DATA_W-1:0]            mem_rdata_i,
   output logic                         done_o,
   output logic                         err_o,
   output logic [DATA_W-1:0]            ent_handle_o,
   output logic [INST_W+INST_SHIFT-1:0] ent_inst_o,
   output logic [ENG_W-1:0]             ent_engine_o,
   output logic [CHAN_W-1:0]            ent_chan_o,
   output logic                         ent_valid_o
);

   localparam int HASH_W     = hash_width(LOG2_MIN, SIZE_W, CHAN_W);
   localparam int INST_OUT_W = INST_W + INST_SHIFT;
   localparam int WORD_BYTES = DATA_W / 8;

   if (BASE_W + PAGE_LOG2 > ADDR_W) begin : g_bad_base
      $error("objhash_lookup: base field does not fit the address");
   end
   if (DATA_W % 8 != 0 || (2 * WORD_BYTES) != (1 << ENTRY_LOG2)) begin : g_bad_entry
      $error("objhash_lookup: an entry must be exactly two data words");
   end

   lk_state_e state_q;

   logic                  fold_load;
   logic                  fold_step;
   logic                  rem_zero;
   logic [HASH_W-1:0]     hash;
   logic                  in_range;

   logic [BASE_W-1:0]     base_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [ADDR_W-1:0]     entry_addr;
   logic [DATA_W-1:0]     hdl_stage_q;

   logic [INST_OUT_W-1:0] dec_inst;
   logic [ENG_W-1:0]      dec_eng;
   logic [CHAN_W-1:0]     dec_chan;
   logic                  dec_valid;

   logic                  done_q;
   logic                  err_q;
   logic [DATA_W-1:0]     ent_handle_q;
   logic [INST_OUT_W-1:0] ent_inst_q;
   logic [ENG_W-1:0]      ent_eng_q;
   logic [CHAN_W-1:0]     ent_chan_q;
   logic                  ent_valid_q;

   assign fold_load = (state_q == ST_IDLE) && start_i;
   assign fold_step = (state_q == ST_FOLD);

   objhash_fold #(
      .HANDLE_W   (HANDLE_W),
      .CHAN_W     (CHAN_W),
      .SIZE_W     (SIZE_W),
      .LOG2_MIN   (LOG2_MIN),
      .ENTRY_LOG2 (ENTRY_LOG2),
      .HASH_W     (HASH_W)
   ) i_fold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (fold_load),
      .step_i     (fold_step),
      .handle_i   (handle_i),
      .chan_i     (chan_i),
      .size_i     (size_i),
      .rem_zero_o (rem_zero),
      .hash_o     (hash),
      .in_range_o (in_range)
   );

   objhash_ctx_decode #(
      .DATA_W     (DATA_W),
      .INST_W     (INST_W),
      .INST_SHIFT (INST_SHIFT),
      .ENG_LSB    (ENG_LSB),
      .ENG_W      (ENG_W),
      .CHAN_LSB   (CHAN_LSB),
      .CHAN_W     (CHAN_W),
      .VALID_BIT  (VALID_BIT)
   ) i_decode (
      .ctx_i   (mem_rdata_i),
      .inst_o  (dec_inst),
      .eng_o   (dec_eng),
      .chan_o  (dec_chan),
      .valid_o (dec_valid)
   );

   assign entry_addr = ADDR_W'({base_q, {PAGE_LOG2{1'b0}}}) + (ADDR_W'(hash) << ENTRY_LOG2);

   assign mem_req_o  = (state_q == ST_RD_HDL) || (state_q == ST_RD_CTX);
   assign mem_addr_o = (state_q == ST_RD_CTX) ? (addr_q + ADDR_W'(WORD_BYTES)) : addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         base_q       <= '0;
         addr_q       <= '0;
         hdl_stage_q  <= '0;
         done_q       <= 1'b0;
         err_q        <= 1'b0;
         ent_handle_q <= '0;
         ent_inst_q   <= '0;
         ent_eng_q    <= '0;
         ent_chan_q   <= '0;
         ent_valid_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  base_q  <= base_i;
                  state_q <= ST_FOLD;
               end
            end
            ST_FOLD: begin
               if (rem_zero) begin
                  if (in_range) begin
                     addr_q  <= entry_addr;
                     state_q <= ST_RD_HDL;
                  end else begin
                     err_q   <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_RD_HDL: begin
               if (mem_ready_i) begin
                  hdl_stage_q <= mem_rdata_i;
                  state_q     <= ST_RD_CTX;
               end
            end
            ST_RD_CTX: begin
               if (mem_ready_i) begin
                  ent_handle_q <= hdl_stage_q;
                  ent_inst_q   <= dec_inst;
                  ent_eng_q    <= dec_eng;
                  ent_chan_q   <= dec_chan;
                  ent_valid_q  <= dec_valid;
                  done_q       <= 1'b1;
                  state_q      <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o       = done_q;
   assign err_o        = err_q;
   assign ent_handle_o = ent_handle_q;
   assign ent_inst_o   = ent_inst_q;
   assign ent_engine_o = ent_eng_q;
   assign ent_chan_o   = ent_chan_q;
   assign ent_valid_o  = ent_valid_q;

endmodule

// File: rtl/objhash_lookup_chk.sv
module objhash_lookup_chk #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int INST_OUT_W = 20,
   parameter int ENG_W      = 2,
   parameter int CHAN_W     = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  mem_req_o,
   input logic [ADDR_W-1:0]     mem_addr_o,
   input logic                  mem_ready_i,
   input logic                  done_o,
   input logic                  err_o,
   input logic [DATA_W-1:0]     ent_handle_o,
   input logic [INST_OUT_W-1:0] ent_inst_o,
   input logic [ENG_W-1:0]      ent_engine_o,
   input logic [CHAN_W-1:0]     ent_chan_o,
   input logic                  ent_valid_o
);

   localparam int WORD_BYTES = DATA_W / 8;

   a_r3_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !mem_req_o);

   a_r3_err_then_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !mem_req_o);

   a_r3_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_o && done_o));

   a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

   a_r4_ctx_follows_hdl: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && $past(mem_req_o && mem_ready_i)) |->
         (mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_BYTES)));

   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(mem_req_o && mem_ready_i));

   a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(ent_handle_o) && $stable(ent_inst_o) && $stable(ent_engine_o)
                   && $stable(ent_chan_o) && $stable(ent_valid_o)));

endmodule

bind objhash_lookup objhash_lookup_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .INST_OUT_W (INST_W + INST_SHIFT),
   .ENG_W      (ENG_W),
   .CHAN_W     (CHAN_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mem_req_o    (mem_req_o),
   .mem_addr_o   (mem_addr_o),
   .mem_ready_i  (mem_ready_i),
   .done_o       (done_o),
   .err_o        (err_o),
   .ent_handle_o (ent_handle_o),
   .ent_inst_o   (ent_inst_o),
   .ent_engine_o (ent_engine_o),
   .ent_chan_o   (ent_chan_o),
   .ent_valid_o  (ent_valid_o)
);

// File: tb/test_objhash_lookup.sv
`timescale 1ns/1ps
module test_objhash_lookup;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] handle_i = '0;
   logic [4:0]  chan_i = '0;
   logic [1:0]  size_i = '0;
   logic [19:0] base_i = '0;
   logic        mem_req_o;
   logic [31:0] mem_addr_o;
   logic        mem_ready_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic        done_o;
   logic        err_o;
   logic [31:0] ent_handle_o;
   logic [19:0] ent_inst_o;
   logic [1:0]  ent_engine_o;
   logic [4:0]  ent_chan_o;
   logic        ent_valid_o;

   always #2.5 clk = ~clk;

   objhash_lookup i_objhash_lookup (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .handle_i     (handle_i),
      .chan_i       (chan_i),
      .size_i       (size_i),
      .base_i       (base_i),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_ready_i  (mem_ready_i),
      .mem_rdata_i  (mem_rdata_i),
      .done_o       (done_o),
      .err_o        (err_o),
      .ent_handle_o (ent_handle_o),
      .ent_inst_o   (ent_inst_o),
      .ent_engine_o (ent_engine_o),
      .ent_chan_o   (ent_chan_o),
      .ent_valid_o  (ent_valid_o)
   );

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   bit ready_rand = 1'b0;
   bit finished = 1'b0;

   logic [31:0] mem [logic [31:0]];

   function automatic logic [31:0] mem_read(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'hBAD0_0000 | {16'h0, a[15:0]};
   endfunction

   // spec-level hash: fold in chunks of (size+11) bits, then mix the channel in
   function automatic logic [31:0] ref_hash(input logic [31:0] h, input logic [4:0] c,
                                            input logic [1:0] s, output int chunks);
      int bits;
      logic [31:0] acc;
      bits = int'(s) + 11;
      acc = '0;
      chunks = 0;
      while (h != 0) begin
         acc = acc ^ (h & ((32'd1 << bits) - 1));
         h = h >> bits;
         chunks++;
      end
      return acc ^ ({27'd0, c} << (bits - 4));
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // behavioural reference model, stepped on the same rising edges
   int          m_phase = 0;
   int          m_left = 0;
   bit          m_fit = 1'b0;
   logic [31:0] m_addr = '0;
   logic [31:0] m_hdl = '0;
   bit          exp_done = 1'b0;
   bit          exp_err = 1'b0;
   logic [31:0] exp_handle = '0;
   logic [19:0] exp_inst = '0;
   logic [1:0]  exp_eng = '0;
   logic [4:0]  exp_chan = '0;
   bit          exp_valid = 1'b0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_phase = 0;
         exp_done = 1'b0;
         exp_err = 1'b0;
      end else begin
         exp_done = 1'b0;
         exp_err = 1'b0;
         case (m_phase)
            0: if (start_i) begin
               logic [31:0] hv;
               hv = ref_hash(handle_i, chan_i, size_i, m_left);
               m_fit = hv < (32'd1 << (int'(size_i) + 9));
               m_addr = {base_i, 12'h000} + (hv << 3);
               m_phase = 1;
            end
            1: if (m_left == 0) begin
               if (m_fit) m_phase = 2;
               else begin
                  exp_err = 1'b1;
                  m_phase = 0;
               end
            end else m_left--;
            2: if (mem_ready_i) begin
               m_hdl = mem_read(m_addr);
               m_phase = 3;
            end
            3: if (mem_ready_i) begin
               logic [31:0] ctx;
               ctx = mem_read(m_addr + 32'd4);
               exp_handle = m_hdl;
               exp_inst = {ctx[15:0], 4'h0};
               exp_eng = ctx[17:16];
               exp_chan = ctx[28:24];
               exp_valid = ctx[31];
               exp_done = 1'b1;
               m_phase = 0;
            end
            default: m_phase = 0;
         endcase
      end
   end

   // compare every cycle away from the active edge, then drive the memory side
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit er;
         er = (m_phase == 2) || (m_phase == 3);
         chk("R7 done_o", {31'd0, done_o}, {31'd0, exp_done});
         chk("R3 R10 err_o", {31'd0, err_o}, {31'd0, exp_err});
         chk("R4 R10 mem_req_o", {31'd0, mem_req_o}, {31'd0, er});
         if (er) chk("R1 R2 R4 mem_addr_o", mem_addr_o, (m_phase == 3) ? m_addr + 32'd4 : m_addr);
         chk("R6 ent_handle_o", ent_handle_o, exp_handle);
         chk("R5 ent_inst_o", {12'd0, ent_inst_o}, {12'd0, exp_inst});
         chk("R5 ent_engine_o", {30'd0, ent_engine_o}, {30'd0, exp_eng});
         chk("R5 ent_chan_o", {27'd0, ent_chan_o}, {27'd0, exp_chan});
         chk("R5 ent_valid_o", {31'd0, ent_valid_o}, {31'd0, exp_valid});
      end
      mem_rdata_i <= mem_read(mem_addr_o);
      mem_ready_i <= ready_rand ? (($urandom % 3) != 0) : 1'b1;
   end

   task automatic run_lookup(input logic [31:0] h, input logic [4:0] c, input logic [1:0] s,
                             input logic [19:0] b, input logic [31:0] ctx, input bit poke);
      int k, n;
      logic [31:0] hv, a;
      bit fit, saw_err, saw_done;
      hv = ref_hash(h, c, s, k);
      fit = hv < (32'd1 << (int'(s) + 9));
      a = {b, 12'h000} + (hv << 3);
      if (fit) begin
         mem[a] = h;
         mem[a + 32'd4] = ctx;
      end
      @(negedge clk);
      handle_i = h; chan_i = c; size_i = s; base_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      saw_err = 1'b0;
      saw_done = 1'b0;
      forever begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (poke && n == 1) begin
            handle_i = ~h; chan_i = c + 5'd1; base_i = b + 20'd3; start_i = 1'b1;
         end else start_i = 1'b0;
         if (err_o || mem_req_o || n > 60) break;
      end
      start_i = 1'b0;
      chk("R10 decision latency", n, k + 1);
      saw_err = err_o;
      chk("R1 R3 range decision", {31'd0, saw_err}, {31'd0, !fit});
      if (!saw_err) begin
         for (int w = 0; w < 200; w++) begin
            @(negedge clk);
            if (done_o) begin
               saw_done = 1'b1;
               break;
            end
         end
         chk("R7 done seen", {31'd0, saw_done}, 32'd1);
         chk("R6 R8 handle word", ent_handle_o, h);
         chk("R5 instance", {12'd0, ent_inst_o}, {12'd0, ctx[15:0], 4'h0});
         chk("R5 engine", {30'd0, ent_engine_o}, {30'd0, ctx[17:16]});
         chk("R5 channel", {27'd0, ent_chan_o}, {27'd0, ctx[28:24]});
         chk("R5 valid", {31'd0, ent_valid_o}, {31'd0, ctx[31]});
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 mem_req_o", {31'd0, mem_req_o}, 32'd0);
      chk("R9 done_o", {31'd0, done_o}, 32'd0);
      chk("R9 err_o", {31'd0, err_o}, 32'd0);
      chk("R9 ent_handle_o", ent_handle_o, 32'd0);
      chk("R9 ent_inst_o", {12'd0, ent_inst_o}, 32'd0);
      chk("R9 ent_valid_o", {31'd0, ent_valid_o}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2: one chunk, size code 0, channel mixed at bit 7 -> hash 0x1A3
      run_lookup(32'h0000_0123, 5'd1, 2'd0, 20'h00010, 32'h8A3D_5678, 1'b0);
      // R10: zero handle folds in no cycles; channel 2 at bit 8 of a size-1 table
      run_lookup(32'h0000_0000, 5'd2, 2'd1, 20'h00020, 32'h0102_ABCD, 1'b0);
      // R2: two chunks folded -> 0xA5
      run_lookup({21'd5, 11'h0A0}, 5'd0, 2'd0, 20'h00030, 32'hDF6E_0001, 1'b0);
      // R1 R3: last entry of a 4 KiB table, then one past it
      run_lookup(32'h0000_01FF, 5'd0, 2'd0, 20'h00040, 32'h9F03_FFFF, 1'b0);
      run_lookup(32'h0000_0200, 5'd0, 2'd0, 20'h00040, 32'h0, 1'b0);
      // R3: outputs keep the last descriptor after an error
      chk("R3 outputs kept", ent_handle_o, 32'h0000_01FF);
      // R1 R2: size code 3, three chunks, channel at bit 10 -> 0xC0F fits, channel 4 does not
      run_lookup(32'hFFFF_FFFF, 5'd3, 2'd3, 20'h00100, 32'h8302_1234, 1'b0);
      run_lookup(32'hFFFF_FFFF, 5'd4, 2'd3, 20'h00100, 32'h0, 1'b0);
      // R8: a start pulse during the fold is ignored
      run_lookup({21'd3, 11'h045}, 5'd0, 2'd0, 20'h00200, 32'h8C01_0042, 1'b1);

      // R4 R7: ready stalls
      ready_rand = 1'b1;
      run_lookup(32'h0000_0077, 5'd1, 2'd2, 20'h00300, 32'h9102_7777, 1'b0);
      for (int i = 0; i < 60; i++) begin
         logic [31:0] h;
         logic [1:0]  s;
         h = $urandom;
         s = 2'($urandom);
         if (i % 2 == 0) h = h & 32'h0000_01FF;
         run_lookup(h, 5'($urandom % 4), s, 20'($urandom % 64), $urandom, (i % 7) == 3);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc == 150000 && !finished) begin
         finished = 1'b1;
         errs++;
         checks++;
         $display("FAIL watchdog: run did not complete act=%0d exp<%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule